// File: doc/BRIEF.md
# Four-Channel Bus-Master DMA Controller

This block moves data between peripherals and memory without the processor doing the copying. The processor sets it up while it is a slave on the system bus. Each of four channels gets a start address, a transfer count and a direction, written through an 8-bit data port. The port has a 4-bit register select, an active-low chip select and active-low read and write strobes. A shared mode register enables channels and sets their directions. A status register reports which channels have finished and which are still enabled.

When an enabled channel raises its request, the block asks the processor for the bus with a hold request. It waits for hold acknowledge before it drives anything. It then serves one transfer at a time, always choosing the lowest-numbered ready channel. For each transfer it drives the low address byte on dedicated pins and pulses the channel's acknowledge. It asserts one memory strobe and one I/O strobe as a pair. It sends the upper address byte over the data bus to an external latch with an address-strobe pulse, and only when that byte has changed. After each transfer the address steps up and the count steps down. The last transfer raises a terminal-count pulse and turns the channel off. Once no enabled channel is requesting, the hold request falls.

Top module: `dma4_ctrl`

## Requirements
- R1: A channel competes only while its `drq` bit is high and its enable bit is set. Among competing channels, the lowest index is served first. A request on a disabled channel never produces an acknowledge.
- R2: `hrq` goes high one clock after a competing request appears while idle. It stays high until `hlda` is seen. No acknowledge, strobe, address drive or address-strobe happens while `hlda` is low.
- R3: Slave registers are selected by `reg_sel`. Value 2n selects the address of channel n and 2n+1 selects its count. Value 8 selects mode on a write and status on a read. Address and count are accessed as two bytes, low byte first. An internal byte pointer flips on every completed read or write of registers 0–7 and is cleared by a mode write. The upper count byte holds only 6 bits, and its top two bits read as 0.
- R4: During a transfer, `maddr_o` carries address bits 7:0 with `maddr_oe` high. In an address-strobe cycle, `db_o` carries address bits 15:8 with `db_oe` high.
- R5: `adstb` pulses for one cycle before a transfer in two cases: on the first transfer after the bus is granted, and whenever the upper address byte differs from the byte last latched during the current grant. Otherwise it does not pulse.
- R6: Each transfer increments the channel address by 1 and decrements the count by 1. If the count was 0, `tc` is high during that transfer, the channel's enable bit is cleared and its terminal-count flag is set. A count of N therefore gives N+1 transfers.
- R7: When no enabled channel is requesting, `hrq` falls. Any remaining requests on disabled channels are ignored.
- R8: The mode write sets channel enables from bits 3:0 and channel directions from bits 7:4. A status read returns the terminal-count flags in bits 3:0 and the enables in bits 7:4. Completing a status read clears the terminal-count flags.
- R9: A transfer lasts one cycle, with exactly one `dack` bit high. Direction 0 (peripheral to memory) pulls `ior_n` and `memw_n` low. Direction 1 (memory to peripheral) pulls `memr_n` and `iow_n` low. Outside a transfer, all four strobes stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Slave chip select, active low |
| rd_n | input | 1 | Slave read strobe, active low |
| wr_n | input | 1 | Slave write strobe, active low |
| reg_sel | input | 4 | Slave register select |
| db_i | input | 8 | Data bus input |
| db_o | output | 8 | Data bus output (register read data or upper address byte) |
| db_oe | output | 1 | Data bus drive enable |
| drq | input | 4 | Channel requests |
| dack | output | 4 | Channel acknowledges, one-hot during a transfer |
| hrq | output | 1 | Hold request to the processor |
| hlda | input | 1 | Hold acknowledge from the processor |
| maddr_o | output | 8 | Low memory address byte |
| maddr_oe | output | 1 | Low address drive enable |
| adstb | output | 1 | Upper-address latch strobe |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| ior_n | output | 1 | I/O read strobe, active low |
| iow_n | output | 1 | I/O write strobe, active low |
| tc | output | 1 | Terminal-count pulse |

## Verification
Some rules are checked at every clock. No bus drive happens without hold acknowledge, and a pending hold request is never dropped early. The acknowledge is one-hot, and the strobes come in pairs and only inside transfers. The address strobe never coincides with a transfer, and terminal count appears only inside a transfer. The scenarios cover the rest, because those behaviours depend on history. They confirm the priority order, the address sequence across an upper-byte boundary, and that the latch strobe is skipped when the upper byte is unchanged. They also cover the byte-pointer register access, the count masking, the status clear-on-read, and the release of the hold request when only a disabled channel is still requesting.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

    localparam int NCH = 4;                 // channels
    localparam int AW  = 16;                // memory address width
    localparam int CW  = 14;                // transfer count width
    localparam int DW  = 8;                 // data bus width
    localparam int RAW = 4;                 // register select width
    localparam int IW  = $clog2(NCH);       // channel index width

    localparam logic [RAW-1:0] REG_MODE = RAW'(2 * NCH);

    typedef logic [IW-1:0] ch_idx_t;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [CW-1:0] cnt;
    } chan_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_SEL,
        S_ADSTB,
        S_XFER
    } seq_state_t;

    function automatic ch_idx_t to_idx(input logic [NCH-1:0] oh);
        ch_idx_t r;
        r = '0;
        for (int i = 0; i < NCH; i++) begin
            if (oh[i]) r = IW'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/dma4_regs.sv
module dma4_regs
    import dma4_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               slv_en,
    input  logic               cs_n,
    input  logic               rd_n,
    input  logic               wr_n,
    input  logic [RAW-1:0]     reg_sel,
    input  logic [DW-1:0]      din,
    output logic [DW-1:0]      dout,
    output logic               dout_en,
    input  logic               upd,
    input  ch_idx_t            upd_ch,
    output chan_t [NCH-1:0]    chans,
    output logic [NCH-1:0]     ch_en,
    output logic [NCH-1:0]     ch_dir
);

    logic           wr_idle_q;
    logic           rd_act_q;
    logic           ptr_hi;
    logic [RAW-1:0] sel_q;
    logic [NCH-1:0] tc_flag;
    logic           wr_go;
    logic           rd_done;
    ch_idx_t        sel_ch;

    assign sel_ch  = reg_sel[IW:1];
    assign wr_go   = !cs_n && !wr_n && wr_idle_q && slv_en;
    assign rd_done = rd_act_q && (cs_n || rd_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idle_q <= 1'b1;
            rd_act_q  <= 1'b0;
            ptr_hi    <= 1'b0;
            sel_q     <= '0;
            tc_flag   <= '0;
            ch_en     <= '0;
            ch_dir    <= '0;
            chans     <= '0;
        end else begin
            wr_idle_q <= cs_n || wr_n;
            rd_act_q  <= dout_en;
            sel_q     <= reg_sel;

            if (rd_done) begin
                if (sel_q < REG_MODE)       ptr_hi  <= !ptr_hi;
                else if (sel_q == REG_MODE) tc_flag <= '0;
            end

            if (wr_go) begin
                if (reg_sel < REG_MODE) begin
                    ptr_hi <= !ptr_hi;
                    case ({reg_sel[0], ptr_hi})
                        2'b00:   chans[sel_ch].addr[DW-1:0]  <= din;
                        2'b01:   chans[sel_ch].addr[AW-1:DW] <= din[AW-DW-1:0];
                        2'b10:   chans[sel_ch].cnt[DW-1:0]   <= din;
                        default: chans[sel_ch].cnt[CW-1:DW]  <= din[CW-DW-1:0];
                    endcase
                end else if (reg_sel == REG_MODE) begin
                    ch_en  <= din[NCH-1:0];
                    ch_dir <= din[2*NCH-1:NCH];
                    ptr_hi <= 1'b0;
                end
            end

            if (upd) begin
                chans[upd_ch].addr <= chans[upd_ch].addr + AW'(1);
                chans[upd_ch].cnt  <= chans[upd_ch].cnt - CW'(1);
                if (chans[upd_ch].cnt == '0) begin
                    ch_en[upd_ch]   <= 1'b0;
                    tc_flag[upd_ch] <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        dout_en = !cs_n && !rd_n && slv_en;
        dout    = '0;
        if (reg_sel < REG_MODE) begin
            case ({reg_sel[0], ptr_hi})
                2'b00:   dout = chans[sel_ch].addr[DW-1:0];
                2'b01:   dout = DW'(chans[sel_ch].addr[AW-1:DW]);
                2'b10:   dout = chans[sel_ch].cnt[DW-1:0];
                default: dout = DW'(chans[sel_ch].cnt[CW-1:DW]);
            endcase
        end else if (reg_sel == REG_MODE) begin
            dout = DW'({ch_en, tc_flag});
        end
    end

endmodule

// File: rtl/dma4_arb.sv
module dma4_arb
    import dma4_pkg::*;
(
    input  logic [NCH-1:0] drq,
    input  logic [NCH-1:0] ch_en,
    output logic [NCH-1:0] grant,
    output logic           any_req
);

    logic [NCH:0]   blocked;
    logic [NCH-1:0] valid;

    assign valid      = drq & ch_en;
    assign blocked[0] = 1'b0;

    for (genvar i = 0; i < NCH; i++) begin : g_chain
        assign grant[i]     = valid[i] && !blocked[i];
        assign blocked[i+1] = blocked[i] || valid[i];
    end

    assign any_req = blocked[NCH];

endmodule

// File: rtl/dma4_seq.sv
module dma4_seq
    import dma4_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            hlda,
    input  logic            any_req,
    input  logic [NCH-1:0]  grant,
    input  chan_t [NCH-1:0] chans,
    output logic            hrq,
    output logic            adstb,
    output logic            xfer,
    output logic            term,
    output ch_idx_t         ch,
    output logic [DW-1:0]   hi_byte
);

    seq_state_t        st;
    logic [AW-DW-1:0]  last_hi;
    logic              hi_ok;
    ch_idx_t           win;
    logic              need_strobe;

    assign win         = to_idx(grant);
    assign need_strobe = !hi_ok || (last_hi != chans[win].addr[AW-1:DW]);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            last_hi <= '0;
            hi_ok   <= 1'b0;
            ch      <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    hi_ok <= 1'b0;
                    if (any_req) st <= S_WAIT;
                end
                S_WAIT: begin
                    if (hlda) st <= S_SEL;
                end
                S_SEL: begin
                    if (!hlda) begin
                        st <= S_WAIT;
                    end else if (!any_req) begin
                        st <= S_IDLE;
                    end else begin
                        ch <= win;
                        st <= need_strobe ? S_ADSTB : S_XFER;
                    end
                end
                S_ADSTB: begin
                    last_hi <= chans[ch].addr[AW-1:DW];
                    hi_ok   <= 1'b1;
                    st      <= S_XFER;
                end
                default: st <= S_SEL;
            endcase
        end
    end

    assign hrq     = (st != S_IDLE);
    assign adstb   = (st == S_ADSTB);
    assign xfer    = (st == S_XFER);
    assign term    = xfer && (chans[ch].cnt == '0);
    assign hi_byte = DW'(chans[ch].addr[AW-1:DW]);

endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
    import dma4_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           cs_n,
    input  logic           rd_n,
    input  logic           wr_n,
    input  logic [3:0]     reg_sel,
    input  logic [7:0]     db_i,
    output logic [7:0]     db_o,
    output logic           db_oe,
    input  logic [3:0]     drq,
    output logic [3:0]     dack,
    output logic           hrq,
    input  logic           hlda,
    output logic [7:0]     maddr_o,
    output logic           maddr_oe,
    output logic           adstb,
    output logic           memr_n,
    output logic           memw_n,
    output logic           ior_n,
    output logic           iow_n,
    output logic           tc
);

    chan_t [NCH-1:0] chans;
    logic [NCH-1:0]  ch_en;
    logic [NCH-1:0]  ch_dir;
    logic [NCH-1:0]  grant;
    logic            any_req;
    logic            xfer;
    ch_idx_t         ch;
    logic [DW-1:0]   hi_byte;
    logic [DW-1:0]   slv_dout;
    logic            slv_oe;
    logic            dir_cur;

    dma4_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .slv_en  (!hlda),
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .reg_sel (reg_sel),
        .din     (db_i),
        .dout    (slv_dout),
        .dout_en (slv_oe),
        .upd     (xfer),
        .upd_ch  (ch),
        .chans   (chans),
        .ch_en   (ch_en),
        .ch_dir  (ch_dir)
    );

    dma4_arb u_arb (
        .drq     (drq),
        .ch_en   (ch_en),
        .grant   (grant),
        .any_req (any_req)
    );

    dma4_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .hlda    (hlda),
        .any_req (any_req),
        .grant   (grant),
        .chans   (chans),
        .hrq     (hrq),
        .adstb   (adstb),
        .xfer    (xfer),
        .term    (tc),
        .ch      (ch),
        .hi_byte (hi_byte)
    );

    assign dir_cur = ch_dir[ch];

    always_comb begin
        dack       = '0;
        if (xfer) dack[ch] = 1'b1;
        memw_n     = !(xfer && !dir_cur);
        ior_n      = !(xfer && !dir_cur);
        memr_n     = !(xfer && dir_cur);
        iow_n      = !(xfer && dir_cur);
        maddr_oe   = xfer;
        maddr_o    = xfer ? chans[ch].addr[DW-1:0] : '0;
        db_oe      = adstb || slv_oe;
        db_o       = adstb ? hi_byte : slv_dout;
    end

endmodule

// File: rtl/dma4_chk.sv
module dma4_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] dack,
    input logic       hrq,
    input logic       hlda,
    input logic       maddr_oe,
    input logic       adstb,
    input logic       db_oe,
    input logic       memr_n,
    input logic       memw_n,
    input logic       ior_n,
    input logic       iow_n,
    input logic       tc
);

    p_dack_single_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dack));

    p_bus_owned_r2: assert property (@(posedge clk) disable iff (rst)
        ((dack != 4'b0) || maddr_oe || adstb) |-> hlda);

    p_hrq_kept_r2: assert property (@(posedge clk) disable iff (rst)
        (hrq && !hlda) |=> hrq);

    p_adstb_alone_r4: assert property (@(posedge clk) disable iff (rst)
        adstb |-> (db_oe && dack == 4'b0 && maddr_oe == 1'b0));

    p_tc_in_xfer_r6: assert property (@(posedge clk) disable iff (rst)
        tc |-> (dack != 4'b0));

    p_strobe_in_xfer_r9: assert property (@(posedge clk) disable iff (rst)
        (!memw_n || !memr_n || !ior_n || !iow_n) |-> (dack != 4'b0));

    p_strobe_pairs_r9: assert property (@(posedge clk) disable iff (rst)
        (memw_n == ior_n) && (memr_n == iow_n) && !(!memw_n && !memr_n));

endmodule

bind dma4_ctrl dma4_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .dack     (dack),
    .hrq      (hrq),
    .hlda     (hlda),
    .maddr_oe (maddr_oe),
    .adstb    (adstb),
    .db_oe    (db_oe),
    .memr_n   (memr_n),
    .memw_n   (memw_n),
    .ior_n    (ior_n),
    .iow_n    (iow_n),
    .tc       (tc)
);

// File: tb/test_dma4_ctrl.sv
module test_dma4_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [3:0] reg_sel = '0;
    logic [7:0] db_i = '0;
    logic [7:0] db_o;
    logic       db_oe;
    logic [3:0] drq = '0;
    logic [3:0] dack;
    logic       hrq;
    logic       hlda = 1'b0;
    logic [7:0] maddr_o;
    logic       maddr_oe, adstb, memr_n, memw_n, ior_n, iow_n, tc;

    always #4 clk = !clk;

    dma4_ctrl i_dma4_ctrl (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .reg_sel(reg_sel), .db_i(db_i), .db_o(db_o), .db_oe(db_oe),
        .drq(drq), .dack(dack), .hrq(hrq), .hlda(hlda),
        .maddr_o(maddr_o), .maddr_oe(maddr_oe), .adstb(adstb),
        .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n), .tc(tc)
    );

    typedef struct {
        int ch;
        int addr;
        bit dir;
        bit last;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0, n_err = 0;
    int   adstb_cnt = 0, tc_cnt = 0, dack2_cnt = 0;
    logic [7:0] lat_hi = '0;
    logic [1:0] hq = '0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // processor side of the hold handshake: grants two cycles after the request
    always @(negedge clk) begin
        if (rst) begin
            hq   <= '0;
            hlda <= 1'b0;
        end else begin
            hq   <= {hq[0], hrq};
            hlda <= hq[1] && hrq;
        end
    end

    // monitor: pops the scoreboard on every acknowledge
    always @(negedge clk) begin
        if (!rst) begin
            if (adstb) begin
                lat_hi = db_o;
                adstb_cnt++;
                check(db_oe, "R4 upper byte drive", db_oe, 1);
            end
            if (tc) tc_cnt++;
            if (dack[2]) dack2_cnt++;
            if (dack != 4'b0) begin
                if (q.size() == 0) begin
                    check(1'b0, "R1 unexpected acknowledge", dack, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(dack == (4'b1 << e.ch), "R1 served channel", dack, 1 << e.ch);
                    check({lat_hi, maddr_o} == e.addr[15:0] && maddr_oe,
                          "R4 full address", {lat_hi, maddr_o}, e.addr);
                    check(hlda, "R2 bus owned", hlda, 1);
                    if (e.dir)
                        check(!memr_n && !iow_n && memw_n && ior_n, "R9 strobes dir1",
                              {memr_n, memw_n, ior_n, iow_n}, 4'b0110);
                    else
                        check(memr_n && iow_n && !memw_n && !ior_n, "R9 strobes dir0",
                              {memr_n, memw_n, ior_n, iow_n}, 4'b1001);
                    check(tc == e.last, "R6 terminal count", tc, e.last);
                end
            end
        end
    end

    task automatic cpu_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; reg_sel = a; db_i = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic cpu_rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; reg_sel = a;
        @(negedge clk);
        d = db_o;
        check(db_oe, "R3 read drive", db_oe, 1);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic rd_check(input logic [3:0] a, input logic [7:0] exp, input string req);
        logic [7:0] d;
        cpu_rd(a, d);
        check(d == exp, req, d, exp);
    endtask

    task automatic expect_run(input int ch, input int addr, input int n, input bit dir);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.ch = ch; e.addr = (addr + i) & 16'hFFFF; e.dir = dir; e.last = (i == n - 1);
            q.push_back(e);
        end
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!hrq && dack == 0 && !db_oe && !tc, "R2 reset idle", {hrq, dack, db_oe, tc}, 0);
        check(memr_n && memw_n && ior_n && iow_n, "R9 reset strobes",
              {memr_n, memw_n, ior_n, iow_n}, 4'hF);

        // R3: channel 0 address 0x12FE, count 2 (three transfers)
        cpu_wr(4'd0, 8'hFE); cpu_wr(4'd0, 8'h12);
        cpu_wr(4'd1, 8'h02); cpu_wr(4'd1, 8'h00);
        rd_check(4'd0, 8'hFE, "R3 addr low");
        rd_check(4'd0, 8'h12, "R3 addr high");
        rd_check(4'd1, 8'h02, "R3 count low");
        rd_check(4'd1, 8'h00, "R3 count high");
        // R3: upper count byte keeps 6 bits
        cpu_wr(4'd5, 8'h00); cpu_wr(4'd5, 8'hFF);
        rd_check(4'd5, 8'h00, "R3 count2 low");
        rd_check(4'd5, 8'h3F, "R3 count2 high masked");

        // R8: enable channel 0, direction 0
        cpu_wr(4'd8, 8'h01);
        rd_check(4'd8, 8'h10, "R8 status enables");

        // R2, R5, R6: run channel 0
        adstb_cnt = 0;
        expect_run(0, 16'h12FE, 3, 1'b0);
        @(negedge clk);
        drq = 4'b0001;
        @(negedge clk);
        check(hrq && dack == 0, "R2 hold request raised", {hrq, dack}, 5'b10000);
        drain();
        check(!hrq, "R7 hold released", hrq, 0);
        check(adstb_cnt == 2, "R5 latch strobes on upper-byte change", adstb_cnt, 2);
        check(tc_cnt == 1, "R6 one terminal count", tc_cnt, 1);
        rd_check(4'd8, 8'h01, "R6 R8 flag set, enable cleared");
        rd_check(4'd8, 8'h00, "R8 flags cleared by read");
        drq = 4'b0000;
        rd_check(4'd0, 8'h01, "R6 addr low after run");
        rd_check(4'd0, 8'h13, "R6 addr high after run");
        rd_check(4'd1, 8'hFF, "R6 count low after run");
        rd_check(4'd1, 8'h3F, "R6 count high after run");

        // R1: channels 1 and 3 enabled, channel 2 requests while disabled
        cpu_wr(4'd2, 8'h40); cpu_wr(4'd2, 8'h00);
        cpu_wr(4'd3, 8'h00); cpu_wr(4'd3, 8'h00);
        cpu_wr(4'd6, 8'h41); cpu_wr(4'd6, 8'h00);
        cpu_wr(4'd7, 8'h00); cpu_wr(4'd7, 8'h00);
        cpu_wr(4'd8, 8'h8A);
        adstb_cnt = 0;
        expect_run(1, 16'h0040, 1, 1'b0);
        expect_run(3, 16'h0041, 1, 1'b1);
        @(negedge clk);
        drq = 4'b1110;
        drain();
        check(dack2_cnt == 0, "R1 disabled channel ignored", dack2_cnt, 0);
        check(!hrq, "R7 release with disabled request pending", hrq, 0);
        check(adstb_cnt == 1, "R5 no strobe when upper byte unchanged", adstb_cnt, 1);
        rd_check(4'd8, 8'h0A, "R8 flags for channels 1 and 3");
        drq = 4'b0000;

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired, pending=%0d expected=0", q.size());
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule